// File: doc/BRIEF.md
# Hypercube Node Packet Router

This block is the switching element that sits at one node of a binary hypercube network of `2**DIM` nodes. Each node owns a `DIM`-bit identifier, and the link for dimension `k` joins it to the node whose identifier differs only in bit `k`. The router accepts single-flit packets on `DIM` link inputs plus one local injection input. It sends each packet out on `DIM` link outputs or on one local ejection output. Every port uses a valid/ready handshake.

Routing is deterministic and corrects the lowest dimension first. The router XORs the packet's destination field with the node's own identifier. A zero result ejects the packet locally. A non-zero result sends the packet on the link of the lowest set bit. Each hop therefore clears exactly one differing bit, and a packet takes as many hops as there are differing bits, never more than `DIM`.

Each input has a single-entry holding slot, a two-state machine (`SLOT_EMPTY`, `SLOT_FULL`). The slot computes the port choice when the packet is accepted. Each output has a round-robin arbiter, also a two-state machine (`ARB_OPEN`, `ARB_HOLD`), over the slots that request it. The arbiter transitions are:

- `ARB_OPEN` to `ARB_HOLD`: the output is offered but not accepted. The current winner is locked.
- `ARB_HOLD` to `ARB_OPEN`: the output accepts.
- `ARB_OPEN` to `ARB_OPEN`: the output is idle, or a transfer completes at once.

The slot transitions are:

- `SLOT_EMPTY` to `SLOT_FULL`: an input handshake.
- `SLOT_FULL` to `SLOT_EMPTY`: the packet's granted output accepts it.

Top module: `hcube_router`

## Requirements
- R1: After reset, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: A flit's destination sits in bits `[DIM-1:0]` and its payload in bits `[DIM+PAY_W-1:DIM]`. When the destination equals `NODE_ID`, the packet leaves on output port `DIM`, the local ejection port.
- R3: When the destination differs from `NODE_ID`, the packet leaves on output port `k`, where `k` is the lowest set bit of `dest XOR NODE_ID`. Input and output ports `0..DIM-1` are the dimension links.
- R4: A packet accepted at a clock edge is offered on its output in the following cycle, with the flit bits unchanged.
- R5: An input's `in_ready` is 0 from the cycle after it accepts a packet until the cycle after that packet leaves. At that point it returns to 1.
- R6: While an offered output sees `out_ready` low, its `out_valid` stays 1 and its `out_flit` does not change.
- R7: Inputs competing for one output are served round-robin. After input `i` wins, the search for the next winner starts at input `i+1`, wrapping around. After reset the search starts at input 0.
- R8: Every accepted packet leaves exactly once. No packet is dropped or duplicated.
- R9: Packets bound for different outputs are offered in the same cycle, independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | DIM+1 | Per-input packet present; bit DIM is local injection |
| in_ready | output | DIM+1 | Per-input slot empty and able to accept |
| in_flit | input | (DIM+1)*(DIM+PAY_W) | Input flits, input j in slice j |
| out_valid | output | DIM+1 | Per-output packet offered; bit DIM is local ejection |
| out_ready | input | DIM+1 | Per-output downstream acceptance |
| out_flit | output | (DIM+1)*(DIM+PAY_W) | Output flits, output j in slice j |

## Verification
The bench builds the router with `DIM = 3`, `PAY_W = 8` and `NODE_ID = 5`. With these values there are four inputs and four outputs. The identifier mixes ones and zeros, so destinations can be chosen to reach every link port through a genuine lowest-set-bit decision rather than a trivial pattern. Four contenders on one output are enough to watch the round-robin pointer wrap fully twice. Random destinations under random backpressure exercise conflicts on all outputs together.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    typedef enum logic {
        ARB_OPEN = 1'b0,
        ARB_HOLD = 1'b1
    } arb_state_e;

endpackage

// File: rtl/hcr_in_slot.sv
module hcr_in_slot
    import hcr_pkg::*;
#(
    parameter int DIM     = 3,
    parameter int PAY_W   = 8,
    parameter int NODE_ID = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [DIM+PAY_W-1:0] in_flit,
    input  logic                 deq,
    output logic [DIM:0]         req,
    output logic [DIM+PAY_W-1:0] flit
);
    localparam int NP = DIM + 1;
    localparam int FW = DIM + PAY_W;
    localparam logic [DIM-1:0] SELF = DIM'(NODE_ID);

    slot_state_e     state_q, state_d;
    logic [FW-1:0]   flit_q;
    logic [NP-1:0]   route_q;
    logic            take;

    function automatic logic [NP-1:0] pick_port(input logic [DIM-1:0] dest);
        logic [DIM-1:0] diff;
        logic [NP-1:0]  r;
        diff = dest ^ SELF;
        r    = '0;
        if (diff == '0) begin
            r[DIM] = 1'b1;
        end else begin
            for (int k = DIM - 1; k >= 0; k--) begin
                if (diff[k]) begin
                    r    = '0;
                    r[k] = 1'b1;
                end
            end
        end
        return r;
    endfunction

    assign take = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flit_q  <= '0;
            route_q <= '0;
        end else if (take) begin
            flit_q  <= in_flit;
            route_q <= pick_port(in_flit[DIM-1:0]);
        end
    end

    always_comb begin
        state_d  = state_q;
        in_ready = 1'b0;
        req      = '0;
        unique case (state_q)
            SLOT_EMPTY: begin
                in_ready = 1'b1;
                if (in_valid) state_d = SLOT_FULL;
            end
            SLOT_FULL: begin
                req = route_q;
                if (deq) state_d = SLOT_EMPTY;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    assign flit = flit_q;

    // R5
    held_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_FULL && !deq) |=> (state_q == SLOT_FULL && $stable(flit_q)));

    // R8
    single_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_FULL) |-> $onehot(req));

endmodule

// File: rtl/hcr_rr_arb.sv
module hcr_rr_arb
    import hcr_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         ready,
    output logic [N-1:0] grant
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    arb_state_e     state_q, state_d;
    logic [PW-1:0]  ptr_q, ptr_d;
    logic [N-1:0]   lock_q, lock_d;
    logic [N-1:0]   pick;
    logic [PW-1:0]  win_idx;

    always_comb begin
        pick = '0;
        for (int off = 0; off < N; off++) begin
            int idx;
            idx = int'(ptr_q) + off;
            if (idx >= N) idx = idx - N;
            if (req[idx] && pick == '0) pick[idx] = 1'b1;
        end
    end

    always_comb begin
        win_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) win_idx = PW'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_OPEN;
            ptr_q   <= '0;
            lock_q  <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            lock_q  <= lock_d;
        end
    end

    always_comb begin
        state_d = state_q;
        lock_d  = lock_q;
        grant   = '0;
        unique case (state_q)
            ARB_OPEN: begin
                grant = pick;
                if (pick != '0 && !ready) begin
                    state_d = ARB_HOLD;
                    lock_d  = pick;
                end
            end
            ARB_HOLD: begin
                grant = lock_q;
                if (ready) begin
                    state_d = ARB_OPEN;
                    lock_d  = '0;
                end
            end
            default: state_d = ARB_OPEN;
        endcase
        ptr_d = ptr_q;
        if (grant != '0 && ready) begin
            ptr_d = (int'(win_idx) == N - 1) ? '0 : win_idx + PW'(1);
        end
    end

    // R7
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R8
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    // R6
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !ready) |=> $stable(grant));

endmodule

// File: rtl/hcube_router.sv
module hcube_router
    import hcr_pkg::*;
#(
    parameter int DIM     = 3,
    parameter int PAY_W   = 8,
    parameter int NODE_ID = 0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [DIM:0]                     in_valid,
    output logic [DIM:0]                     in_ready,
    input  logic [(DIM+1)*(DIM+PAY_W)-1:0]   in_flit,
    output logic [DIM:0]                     out_valid,
    input  logic [DIM:0]                     out_ready,
    output logic [(DIM+1)*(DIM+PAY_W)-1:0]   out_flit
);
    localparam int NP = DIM + 1;
    localparam int FW = DIM + PAY_W;
    localparam logic [DIM-1:0] SELF = DIM'(NODE_ID);

    logic [NP-1:0] slot_req  [NP];
    logic [FW-1:0] slot_flit [NP];
    logic [NP-1:0] grant     [NP];
    logic [NP-1:0] req_col   [NP];
    logic [NP-1:0] deq;

    for (genvar i = 0; i < NP; i++) begin : g_in
        hcr_in_slot #(
            .DIM     (DIM),
            .PAY_W   (PAY_W),
            .NODE_ID (NODE_ID)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid[i]),
            .in_ready (in_ready[i]),
            .in_flit  (in_flit[i*FW +: FW]),
            .deq      (deq[i]),
            .req      (slot_req[i]),
            .flit     (slot_flit[i])
        );
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        for (genvar i = 0; i < NP; i++) begin : g_col
            assign req_col[o][i] = slot_req[i][o];
        end

        hcr_rr_arb #(.N(NP)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_col[o]),
            .ready (out_ready[o]),
            .grant (grant[o])
        );

        always_comb begin
            logic [FW-1:0] acc;
            acc = '0;
            for (int i = 0; i < NP; i++) begin
                acc = acc | (slot_flit[i] & {FW{grant[o][i]}});
            end
            out_flit[o*FW +: FW] = acc;
        end

        assign out_valid[o] = |grant[o];

        // R6
        out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(out_flit[o*FW +: FW])));

        if (o < DIM) begin : g_link_chk
            // R3
            link_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid[o] |-> (((out_flit[o*FW +: DIM] ^ SELF) & DIM'((1 << (o + 1)) - 1))
                                  == DIM'(1 << o)));
        end else begin : g_local_chk
            // R2
            local_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid[o] |-> (out_flit[o*FW +: DIM] == SELF));
        end
    end

    always_comb begin
        deq = '0;
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                if (grant[o][i] && out_ready[o]) deq[i] = 1'b1;
            end
        end
    end

    // R8
    one_output_per_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({grant[0] & grant[1], grant[0] & grant[2], grant[0] & grant[3],
                    grant[1] & grant[2], grant[1] & grant[3], grant[2] & grant[3]}) == 0
        || NP != 4);

endmodule

// File: tb/hcube_router_bench.sv
module hcube_router_bench;
    localparam int DIM   = 3;
    localparam int PAY_W = 8;
    localparam int ID    = 5;
    localparam int NP    = DIM + 1;
    localparam int FW    = DIM + PAY_W;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NP-1:0]       in_valid = '0;
    logic [NP-1:0]       in_ready;
    logic [NP*FW-1:0]    in_flit = '0;
    logic [NP-1:0]       out_valid;
    logic [NP-1:0]       out_ready = '1;
    logic [NP*FW-1:0]    out_flit;

    int checks = 0;
    int fails  = 0;
    logic [FW-1:0] expq [NP][$];
    int            seen [NP][$];
    int            mptr [NP];
    bit            stress_on = 1'b0;

    always #2 clk = ~clk;

    hcube_router #(.DIM(DIM), .PAY_W(PAY_W), .NODE_ID(ID)) u_hcube_router (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_flit(in_flit), .out_valid(out_valid), .out_ready(out_ready),
        .out_flit(out_flit)
    );

    function automatic int exp_port(input logic [DIM-1:0] dest);
        logic [DIM-1:0] d;
        d = dest ^ DIM'(ID);
        if (d == '0) return DIM;
        for (int k = 0; k < DIM; k++) if (d[k]) return k;
        return DIM;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input int p, input logic [DIM-1:0] dest, input logic [5:0] tag);
        logic [FW-1:0] f;
        f = {tag, 2'(p), dest};
        @(negedge clk);
        while (!in_ready[p]) @(negedge clk);
        in_valid[p] = 1'b1;
        in_flit[p*FW +: FW] = f;
        @(negedge clk);
        in_valid[p] = 1'b0;
        expq[exp_port(dest)].push_back(f);
    endtask

    // monitor: scoreboard pop (R2, R3, R8) and arbitration trace (R7)
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            for (int o = 0; o < NP; o++) begin
                if (out_valid[o] && out_ready[o]) begin
                    logic [FW-1:0] f;
                    int hit;
                    f = out_flit[o*FW +: FW];
                    hit = -1;
                    for (int j = 0; j < expq[o].size(); j++)
                        if (hit < 0 && expq[o][j] == f) hit = j;
                    if (o == DIM) check(hit >= 0, "R2", "local eject item", f, 0);
                    else          check(hit >= 0, "R3", "link item", f, o);
                    if (hit >= 0) expq[o].delete(hit);
                    seen[o].push_back(int'(f[DIM +: 2]));
                    mptr[o] = (int'(f[DIM +: 2]) + 1) % NP;
                end
            end
        end
    end

    initial begin
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int o = 0; o < NP; o++) mptr[o] = 0;
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == '0, "R1", "out_valid in reset", out_valid, 0);
        check(in_ready == '1, "R1", "in_ready in reset", in_ready, 4'hf);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(out_valid == '0 && in_ready == '1, "R1", "idle after reset",
              {out_valid, in_ready}, 8'h0f);

        // R4 and R5: latency and slot occupancy
        send(1, 3'b100, 6'h11);
        #1;
        check(out_valid[0] == 1'b1, "R4", "offered next cycle", out_valid, 1);
        check(out_flit[0 +: FW] == {6'h11, 2'd1, 3'b100}, "R4", "flit intact",
              out_flit[0 +: FW], {6'h11, 2'd1, 3'b100});
        check(in_ready[1] == 1'b0, "R5", "slot busy", in_ready[1], 0);
        @(negedge clk); #1;
        check(in_ready[1] == 1'b1 && out_valid[0] == 1'b0, "R5", "slot free after leave",
              {in_ready[1], out_valid[0]}, 2'b10);

        // R2 and R3: each port reached
        send(0, 3'b101, 6'h01);
        send(2, 3'b110, 6'h02);
        send(3, 3'b111, 6'h03);
        send(0, 3'b011, 6'h04);
        send(1, 3'b001, 6'h05);
        send(3, 3'b000, 6'h06);
        repeat (4) @(negedge clk);

        // R6: backpressure
        out_ready[0] = 1'b0;
        send(2, 3'b100, 6'h2a);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk); #1;
            check(out_valid[0] && out_flit[0 +: FW] == {6'h2a, 2'd2, 3'b100}, "R6",
                  "held under stall", out_flit[0 +: FW], {6'h2a, 2'd2, 3'b100});
            check(in_ready[2] == 1'b0, "R5", "slot busy under stall", in_ready[2], 0);
        end
        @(negedge clk);
        out_ready[0] = 1'b1;
        repeat (3) @(negedge clk);

        // R9: parallel outputs
        fork
            send(0, 3'b100, 6'h31);
            send(1, 3'b111, 6'h32);
        join
        #1;
        check(out_valid[0] && out_valid[1], "R9", "two outputs together", out_valid, 4'b0011);
        repeat (3) @(negedge clk);

        // R7: two rounds of round-robin on the local output
        for (int round = 0; round < 2; round++) begin
            int order [NP];
            out_ready[DIM] = 1'b0;
            fork
                send(0, 3'b101, 6'h20);
                send(1, 3'b101, 6'h21);
                send(2, 3'b101, 6'h22);
                send(3, 3'b101, 6'h23);
            join
            for (int k = 0; k < NP; k++) order[k] = (mptr[DIM] + k) % NP;
            seen[DIM].delete();
            repeat (2) @(negedge clk);
            out_ready[DIM] = 1'b1;
            repeat (8) @(negedge clk);
            check(seen[DIM].size() == NP, "R7", "grant count", seen[DIM].size(), NP);
            for (int k = 0; k < NP; k++) begin
                if (k < seen[DIM].size())
                    check(seen[DIM][k] == order[k], "R7", "grant order",
                          seen[DIM][k], order[k]);
            end
        end

        // R8: random traffic under random backpressure
        stress_on = 1'b1;
        fork
            begin
                while (stress_on) begin
                    @(negedge clk);
                    out_ready = 4'($urandom);
                end
            end
            begin
                fork
                    for (int n = 0; n < 40; n++) send(0, 3'($urandom), 6'(n));
                    for (int n = 0; n < 40; n++) send(1, 3'($urandom), 6'(n));
                    for (int n = 0; n < 40; n++) send(2, 3'($urandom), 6'(n));
                    for (int n = 0; n < 40; n++) send(3, 3'($urandom), 6'(n));
                join
                stress_on = 1'b0;
            end
        join
        @(negedge clk);
        out_ready = '1;
        repeat (20) @(negedge clk);
        #1;
        for (int o = 0; o < NP; o++)
            check(expq[o].size() == 0, "R8", "nothing left undelivered", expq[o].size(), 0);
        check(out_valid == '0 && in_ready == '1, "R8", "drained", {out_valid, in_ready}, 8'h0f);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule